// File: doc/BRIEF.md
# Transfer Byte Counter with End-of-Transfer Generation

This block sits beside the buffer-memory port of a host controller and tracks how many bytes a transfer has moved. Software loads a 16-bit byte count and a small DMA configuration word through a command interface. The configuration word sets three things: whether the hardware counter is in use, which buffer is targeted (isochronous list or acknowledged list), and the transfer direction.

While a transfer runs, every accepted 16-bit data beat adds two bytes to an internal tally. When the tally reaches or passes the programmed count, the block raises an end-of-transfer event. That event does three things:
- sets a sticky interrupt flag,
- pulses a buffer-status update for one cycle,
- drops the DMA request.

With the counter bypassed, only an external end-of-transfer input can close the transfer.

Command codes have bit 7 set for a write and clear for a read. The low seven bits select the register:
- 0x22 selects the byte count.
- 0x21 selects the configuration.
- 0x24 selects the interrupt register.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset, the count register reads 0, the configuration reads 0, both interrupt flags are 0, and dmaReq and bufStatusPulse are 0.
- R2: Code 0xA2 writes cmdWData into the count register. While cmdValid is high with code 0x22, rdData shows that register.
- R3: A count write is rejected if its value is above the limit of the buffer selected at that moment: 0x1000 for the acknowledged list (config bit 1 = 1) and 0x800 for the isochronous list (bit 1 = 0). A rejected write leaves the register unchanged and sets the sticky rangeErr flag, which is interrupt register bit 3.
- R4: When the counter is enabled, each beat accepted while dmaReq is high adds 2 bytes. End-of-transfer happens on the beat that brings the tally to or past the programmed count, so an odd count finishes on the beat that passes it.
- R5: End-of-transfer sets eotIrq (interrupt register bit 2) and pulses bufStatusPulse high for exactly one cycle. In that same cycle dmaReq is already low.
- R6: After end-of-transfer, dmaReq stays low until dmaEnable is taken low and then raised again.
- R7: When the counter is enabled and the count is zero, a rising dmaEnable does not raise dmaReq.
- R8: When config bit 2 is 0, beats never end the transfer and extEot does. When bit 2 is 1, extEot has no effect.
- R9: A write with code 0xA4 clears each interrupt flag whose data bit is 1 (bit 2 for eotIrq, bit 3 for rangeErr). Flags whose data bit is 0 are kept. Reading with code 0x24 returns the flags at bits 2 and 3.
- R10: Code 0xA1 writes and code 0x21 reads the configuration word:
  - bit 2 enables the counter,
  - bit 1 selects the buffer, shown on bufSel,
  - bit 0 selects the direction (1 = write to the buffer), shown on dirWrite.
- R11: Taking dmaEnable low drops dmaReq at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code; bit 7 = write |
| cmdWData | input | 16 | Write data |
| rdData | output | 16 | Read data for the current read command, else 0 |
| dmaEnable | input | 1 | DMA enable from software |
| beatValid | input | 1 | One 16-bit data beat accepted this cycle |
| extEot | input | 1 | External end-of-transfer |
| dmaReq | output | 1 | DMA request |
| eotIrq | output | 1 | Sticky end-of-transfer interrupt flag |
| rangeErr | output | 1 | Sticky rejected-count flag |
| bufStatusPulse | output | 1 | One-cycle buffer-status update |
| bufSel | output | 1 | Selected buffer (1 = acknowledged list) |
| dirWrite | output | 1 | Transfer direction (1 = write to buffer) |

## Verification
The checker assumes that software does not write a zero count in the same cycle that dmaEnable rises. It also assumes beats arrive only while dmaReq is high. The directed tests follow both rules: they reprogram the count only while dmaEnable is low, and they present beats only during an open transfer. The tests also assume the interrupt clear is never issued in the same cycle as a finishing beat. The bench therefore keeps W1C writes and transfers apart.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 7'h22;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 7'h21;
  localparam logic [ADDR_W-1:0] ADDR_IRQ = 7'h24;
  localparam int CFG_CNT_EN = 2;
  localparam int CFG_BUF = 1;
  localparam int CFG_DIR = 0;
  localparam int IRQ_EOT = 2;
  localparam int IRQ_RANGE = 3;

  typedef struct packed {
    logic wrCount;
    logic clrMoved;
    logic advance;
  } ctlStrobes_t;
endpackage

// File: rtl/xbc_datapath.sv
module xbc_datapath
  import xbc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BEAT_BYTES = 2,
  parameter logic [CW-1:0] ITL_MAX = 16'h0800,
  parameter logic [CW-1:0] ATL_MAX = 16'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [CW-1:0] wrData,
  input  logic          bufSel,
  output logic [CW-1:0] countVal,
  output logic          limitOk,
  output logic          countZero,
  output logic          reachEnd
);
  localparam int MW = CW + 1;

  logic [CW-1:0] countReg;
  logic [MW-1:0] moved;
  logic [MW-1:0] movedNext;
  logic [CW-1:0] limitSel;

  assign limitSel = bufSel ? ATL_MAX : ITL_MAX;
  assign limitOk = (wrData <= limitSel);
  assign countZero = (countReg == '0);
  assign movedNext = moved + MW'(BEAT_BYTES);
  assign reachEnd = (movedNext >= {1'b0, countReg});
  assign countVal = countReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      moved <= '0;
    end else begin
      if (strobes.wrCount) countReg <= wrData;
      if (strobes.clrMoved) moved <= '0;
      else if (strobes.advance) moved <= movedNext;
    end
  end
endmodule

// File: rtl/xbc_ctrl.sv
module xbc_ctrl
  import xbc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [7:0]    cmdCode,
  input  logic [CW-1:0] cmdWData,
  input  logic          dmaEnable,
  input  logic          beatValid,
  input  logic          extEot,
  input  logic [CW-1:0] countVal,
  input  logic          limitOk,
  input  logic          countZero,
  input  logic          reachEnd,
  output ctlStrobes_t   strobes,
  output logic [2:0]    cfgBits,
  output logic [CW-1:0] rdData,
  output logic          dmaReq,
  output logic          eotIrq,
  output logic          rangeErr,
  output logic          bufStatusPulse
);
  logic isWr, isRd;
  logic [ADDR_W-1:0] addr;
  logic enPrev, active, start, finish, cntWrite, irqClr;

  assign isWr = cmdValid && cmdCode[7];
  assign isRd = cmdValid && !cmdCode[7];
  assign addr = cmdCode[ADDR_W-1:0];
  assign cntWrite = isWr && (addr == ADDR_CNT);
  assign irqClr = isWr && (addr == ADDR_IRQ);
  assign start = dmaEnable && !enPrev;
  assign finish = active && dmaEnable &&
                  (cfgBits[CFG_CNT_EN] ? (beatValid && reachEnd) : extEot);

  always_comb begin
    strobes.wrCount = cntWrite && limitOk;
    strobes.clrMoved = start;
    strobes.advance = active && beatValid && !start;
  end

  always_comb begin
    rdData = '0;
    if (isRd) begin
      case (addr)
        ADDR_CNT: rdData = countVal;
        ADDR_CFG: rdData = CW'(cfgBits);
        ADDR_IRQ: begin
          rdData[IRQ_EOT] = eotIrq;
          rdData[IRQ_RANGE] = rangeErr;
        end
        default: rdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
      enPrev <= 1'b0;
      active <= 1'b0;
      eotIrq <= 1'b0;
      rangeErr <= 1'b0;
      bufStatusPulse <= 1'b0;
    end else begin
      enPrev <= dmaEnable;
      if (isWr && addr == ADDR_CFG) cfgBits <= cmdWData[2:0];
      if (!dmaEnable) active <= 1'b0;
      else if (start) active <= cfgBits[CFG_CNT_EN] ? !countZero : 1'b1;
      else if (finish) active <= 1'b0;
      bufStatusPulse <= finish;
      if (finish) eotIrq <= 1'b1;
      else if (irqClr && cmdWData[IRQ_EOT]) eotIrq <= 1'b0;
      if (cntWrite && !limitOk) rangeErr <= 1'b1;
      else if (irqClr && cmdWData[IRQ_RANGE]) rangeErr <= 1'b0;
    end
  end

  assign dmaReq = active;
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xbc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BEAT_BYTES = 2,
  parameter logic [CW-1:0] ITL_MAX = 16'h0800,
  parameter logic [CW-1:0] ATL_MAX = 16'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [7:0]    cmdCode,
  input  logic [CW-1:0] cmdWData,
  output logic [CW-1:0] rdData,
  input  logic          dmaEnable,
  input  logic          beatValid,
  input  logic          extEot,
  output logic          dmaReq,
  output logic          eotIrq,
  output logic          rangeErr,
  output logic          bufStatusPulse,
  output logic          bufSel,
  output logic          dirWrite
);
  ctlStrobes_t strobes;
  logic [2:0] cfgBits;
  logic [CW-1:0] countVal;
  logic limitOk, countZero, reachEnd;

  xbc_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdWData(cmdWData), .dmaEnable(dmaEnable), .beatValid(beatValid),
    .extEot(extEot), .countVal(countVal), .limitOk(limitOk),
    .countZero(countZero), .reachEnd(reachEnd), .strobes(strobes),
    .cfgBits(cfgBits), .rdData(rdData), .dmaReq(dmaReq), .eotIrq(eotIrq),
    .rangeErr(rangeErr), .bufStatusPulse(bufStatusPulse)
  );

  xbc_datapath #(.CW(CW), .BEAT_BYTES(BEAT_BYTES), .ITL_MAX(ITL_MAX),
                 .ATL_MAX(ATL_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(cmdWData),
    .bufSel(cfgBits[CFG_BUF]), .countVal(countVal), .limitOk(limitOk),
    .countZero(countZero), .reachEnd(reachEnd)
  );

  assign bufSel = cfgBits[CFG_BUF];
  assign dirWrite = cfgBits[CFG_DIR];
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int CW = 16,
  parameter logic [CW-1:0] ATL_MAX = 16'h1000
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [7:0]    cmdCode,
  input logic [CW-1:0] cmdWData,
  input logic          dmaEnable,
  input logic          dmaReq,
  input logic          eotIrq,
  input logic          bufStatusPulse,
  input logic [2:0]    cfgBits,
  input logic [CW-1:0] countVal
);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufStatusPulse |=> !bufStatusPulse);

  p_pulse_with_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufStatusPulse |-> (eotIrq && !dmaReq));

  p_disable_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |=> !dmaReq);

  p_zero_no_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dmaReq) && $past(cfgBits[2])) |-> ($past(countVal) != '0));

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    countVal <= ATL_MAX);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eotIrq && !(cmdValid && cmdCode == 8'hA4 && cmdWData[2])) |=> eotIrq);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && $past(dmaEnable) && dmaEnable) |=> !dmaReq);
endmodule

bind xfer_byte_counter xbc_checker #(.CW(CW), .ATL_MAX(ATL_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdWData(cmdWData), .dmaEnable(dmaEnable), .dmaReq(dmaReq),
  .eotIrq(eotIrq), .bufStatusPulse(bufStatusPulse), .cfgBits(cfgBits),
  .countVal(countVal)
);

// File: tb/tb_xfer_byte_counter.sv
module tb_xfer_byte_counter;
  logic clk = 0, rstN = 0;
  logic cmdValid = 0;
  logic [7:0] cmdCode = 0;
  logic [15:0] cmdWData = 0;
  logic [15:0] rdData;
  logic dmaEnable = 0, beatValid = 0, extEot = 0;
  logic dmaReq, eotIrq, rangeErr, bufStatusPulse, bufSel, dirWrite;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xfer_byte_counter dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1; cmdCode = code; cmdWData = d;
    @(negedge clk);
    cmdValid = 0; cmdCode = 0; cmdWData = 0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [15:0] d);
    @(negedge clk);
    cmdValid = 1; cmdCode = code;
    #1 d = rdData;
    @(negedge clk);
    cmdValid = 0; cmdCode = 0;
  endtask

  task automatic startDma();
    @(negedge clk); dmaEnable = 1;
    @(negedge clk);
  endtask

  task automatic stopDma();
    @(negedge clk); dmaEnable = 0;
    @(negedge clk);
  endtask

  task automatic beat();
    beatValid = 1;
    @(negedge clk);
    beatValid = 0;
  endtask

  task automatic tReset();
    logic [15:0] v;
    check("R1 dmaReq", {15'b0, dmaReq}, 0);
    check("R1 eotIrq", {15'b0, eotIrq}, 0);
    check("R1 pulse", {15'b0, bufStatusPulse}, 0);
    rd(8'h22, v); check("R1 count", v, 0);
    rd(8'h21, v); check("R1 cfg", v, 0);
    rd(8'h24, v); check("R1 irq", v, 0);
  endtask

  task automatic tConfig();
    logic [15:0] v;
    wr(8'hA1, 16'h0003);
    rd(8'h21, v); check("R10 cfg read", v, 16'h0003);
    check("R10 bufSel", {15'b0, bufSel}, 1);
    check("R10 dirWrite", {15'b0, dirWrite}, 1);
  endtask

  task automatic tLimits();
    logic [15:0] v;
    wr(8'hA1, 16'h0006);
    wr(8'hA2, 16'h1000);
    rd(8'h22, v); check("R2 count readback", v, 16'h1000);
    check("R3 no err at ATL max", {15'b0, rangeErr}, 0);
    wr(8'hA2, 16'h1001);
    rd(8'h22, v); check("R3 ATL over kept", v, 16'h1000);
    check("R3 rangeErr set", {15'b0, rangeErr}, 1);
    wr(8'hA1, 16'h0004);
    wr(8'hA2, 16'h0800);
    rd(8'h22, v); check("R3 ITL max accepted", v, 16'h0800);
    wr(8'hA2, 16'h0801);
    rd(8'h22, v); check("R3 ITL over kept", v, 16'h0800);
    rd(8'h24, v); check("R9 irq read range", v, 16'h0008);
    wr(8'hA4, 16'h0004);
    check("R9 bit2 keeps rangeErr", {15'b0, rangeErr}, 1);
    wr(8'hA4, 16'h0008);
    check("R9 clear rangeErr", {15'b0, rangeErr}, 0);
  endtask

  task automatic tTransfer(input logic [15:0] cnt, input int beats);
    wr(8'hA1, 16'h0004);
    wr(8'hA2, cnt);
    startDma();
    check("R4 req up", {15'b0, dmaReq}, 1);
    for (int i = 0; i < beats - 1; i++) beat();
    check("R4 not done early", {15'b0, dmaReq}, 1);
    check("R4 no irq early", {15'b0, eotIrq}, 0);
    beat();
    check("R5 req low at eot", {15'b0, dmaReq}, 0);
    check("R5 pulse", {15'b0, bufStatusPulse}, 1);
    check("R5 irq", {15'b0, eotIrq}, 1);
    @(negedge clk);
    check("R5 pulse single", {15'b0, bufStatusPulse}, 0);
    repeat (3) @(negedge clk);
    check("R6 stays low", {15'b0, dmaReq}, 0);
    stopDma();
    wr(8'hA4, 16'h0004);
    check("R9 clear eot", {15'b0, eotIrq}, 0);
  endtask

  task automatic tRestart();
    wr(8'hA2, 16'h0004);
    startDma();
    check("R6 re-armed", {15'b0, dmaReq}, 1);
    @(negedge clk); dmaEnable = 0;
    @(negedge clk);
    check("R11 disable drops", {15'b0, dmaReq}, 0);
  endtask

  task automatic tZero();
    wr(8'hA2, 16'h0000);
    startDma();
    check("R7 zero no req", {15'b0, dmaReq}, 0);
    stopDma();
  endtask

  task automatic tBypass();
    wr(8'hA2, 16'h0002);
    startDma();
    extEot = 1; @(negedge clk); extEot = 0;
    check("R8 extEot ignored", {15'b0, dmaReq}, 1);
    check("R8 no irq", {15'b0, eotIrq}, 0);
    stopDma();
    wr(8'hA1, 16'h0000);
    startDma();
    check("R8 bypass req", {15'b0, dmaReq}, 1);
    repeat (4) beat();
    check("R8 beats no end", {15'b0, dmaReq}, 1);
    extEot = 1; @(negedge clk); extEot = 0;
    check("R8 ext ends", {15'b0, dmaReq}, 0);
    check("R8 irq", {15'b0, eotIrq}, 1);
    stopDma();
    wr(8'hA4, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tConfig();
    tLimits();
    tTransfer(16'h0004, 2);
    tTransfer(16'h0005, 3);
    tRestart();
    tZero();
    tBypass();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule